// File: doc/BRIEF.md
# Flash Array Signature Checker

This block reads every word of the chosen flash blocks and folds each returned 160-bit data beat into a multiple-input signature register (MISR). Software loads a seed into the five 32-bit signature words, picks blocks in a mask register, and sets an enable bit. It polls a done flag and reads the signature back to compare it with a value it computed offline. Clearing enable before done stops the scan. The signature then holds a partial result.

Normal scans walk the words of each block in ascending order, or in bit-reversed word order when the order-select bit is set. In margin-read mode the order is always ascending and the order-select bit is ignored. The margin level goes out to the array with every read, and a bypass flag tells the array to return raw data with no ECC correction or detection. The array port is a plain synchronous read: the address is presented with a strobe, and the data comes back on the next cycle.

Top module: `sig_scan_ctrl`

## Requirements
- R1: After reset the control register (offset 0), mask register (offset 1) and all five signature words (offsets 2 to 6) read as zero, and no array read is issued.
- R2: Writing offset 0 with bit 0 (enable) set while idle starts a scan. Bit 1 (done) of offset 0 reads 1 once every selected word has been absorbed, and exactly one read is issued for each such word.
- R3: With bit 2 (order select) clear, blocks are visited in ascending order. Within each block the word index runs 0 upward. The read address is {block, word}, with the word in the low WBITS bits.
- R4: With bit 2 set and margin mode off, the word field of each address is the bit-reversal of the running word count. Blocks are still ascending.
- R5: With bit 3 (margin enable) set, addresses are ascending whatever bit 2 holds. Every read carries rd_ecc_bypass = 1 and rd_margin_val equal to bit 4. Normal scans drive rd_ecc_bypass = 0.
- R6: A block is read only if its mask bit is 1 and its lock input is 0 at the start of the scan. Unread blocks leave the signature untouched.
- R7: The block field of the read address never reaches NBLK. That index is the shadow block, which is never read.
- R8: Each beat D arriving one cycle after its read updates the signature S to (S << 1) XOR D, further XORed with taps at bits 159, 158, 157 and 0 when bit 159 of S was 1. Signature word k (offset 2+k) holds S[32k+31:32k].
- R9: Writes to the signature words take effect only while idle. Writes during a scan or while done is set are ignored.
- R10: Clearing enable before done returns the block to idle with done low. The signature then keeps the value reached after a prefix of the beats and no longer changes.
- R11: Writing 0 to enable after done returns the block to idle. Done and enable read 0, and the signature is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| blk_lock | input | NBLK | Per-block lock, 1 = locked |
| rd_en | output | 1 | Array read strobe |
| rd_addr | output | clog2(NBLK+1)+WBITS | Array address {block, word} |
| rd_margin_val | output | 1 | Margin level for the array (1 = ones margin) |
| rd_ecc_bypass | output | 1 | Raw read, no ECC applied |
| rd_data | input | 160 | Array data, valid the cycle after rd_en |

## Verification
The lock and unlocked-read assertions assume that blk_lock stays stable while a scan is in progress. The bench changes the locks only while the block is idle. The assertions also assume that the array returns data exactly one cycle after the strobe. The bench array model is a single register that computes a data beat from the address, so this always holds. Register accesses are single-cycle strobes driven between clock edges, so a write never overlaps the edge at which the bench samples.

// File: rtl/sig_pkg.sv
package sig_pkg;

  localparam int SIG_WORDS = 5;
  localparam int SIG_W     = SIG_WORDS * 32;

  // feedback taps of x^160 + x^159 + x^158 + x^157 + 1
  localparam logic [SIG_W-1:0] SIG_TAPS =
    (SIG_W'(1) << 159) | (SIG_W'(1) << 158) | (SIG_W'(1) << 157) | SIG_W'(1);

  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_MASK = 3'd1;
  localparam logic [2:0] RA_SIG0 = 3'd2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_DRAIN = 2'd2,
    ST_DONE  = 2'd3
  } scan_st_e;

endpackage

// File: rtl/sig_addr_gen.sv
module sig_addr_gen #(
  parameter int NBLK  = 4,
  parameter int WBITS = 3,
  parameter int BBITS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [NBLK-1:0]  act,
  input  logic             alt,
  output logic [BBITS-1:0] blk_o,
  output logic [WBITS-1:0] word_o,
  output logic             cur_act_o,
  output logic             last_o
);

  localparam int BSPAN = 1 << BBITS;

  logic [BBITS-1:0] blk_q, blk_d;
  logic [WBITS-1:0] cnt_q, cnt_d;
  logic [WBITS-1:0] cnt_rev;
  logic [BSPAN-1:0] act_ext;
  logic             wrap;

  for (genvar i = 0; i < WBITS; i++) begin : g_rev
    assign cnt_rev[i] = cnt_q[WBITS-1-i];
  end

  assign act_ext   = BSPAN'(act);
  assign cur_act_o = act_ext[blk_q];
  assign wrap      = !cur_act_o || (cnt_q == {WBITS{1'b1}});
  assign last_o    = (blk_q == BBITS'(NBLK-1)) && wrap;
  assign blk_o     = blk_q;
  assign word_o    = alt ? cnt_rev : cnt_q;

  always_comb begin
    blk_d = blk_q;
    cnt_d = cnt_q;
    if (load) begin
      blk_d = '0;
      cnt_d = '0;
    end else if (step) begin
      if (wrap) begin
        blk_d = blk_q + 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q <= '0;
      cnt_q <= '0;
    end else if (load || step) begin
      blk_q <= blk_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/sig_misr.sv
module sig_misr #(
  parameter int              NWORD = 5,
  parameter logic [NWORD*32-1:0] TAPS = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NWORD-1:0]     seed_we,
  input  logic [31:0]          seed_wdata,
  input  logic                 upd,
  input  logic [NWORD*32-1:0]  beat,
  output logic [NWORD*32-1:0]  sig_o
);

  localparam int W = NWORD * 32;

  logic [W-1:0] sig_q, sig_d;
  logic         sig_we;

  assign sig_we = upd || (|seed_we);
  assign sig_o  = sig_q;

  always_comb begin
    sig_d = sig_q;
    if (upd) begin
      sig_d = {sig_q[W-2:0], 1'b0} ^ beat ^ (sig_q[W-1] ? TAPS : '0);
    end
    for (int k = 0; k < NWORD; k++) begin
      if (seed_we[k]) sig_d[k*32 +: 32] = seed_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= '0;
    else if (sig_we) sig_q <= sig_d;
  end

  // R10: without an update or seed write the signature holds
  p_sig_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd && !(|seed_we)) |=> $stable(sig_o));

endmodule

// File: rtl/sig_scan_ctrl.sv
module sig_scan_ctrl
  import sig_pkg::*;
#(
  parameter int NBLK  = 4,
  parameter int WBITS = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              reg_wr,
  input  logic [2:0]                        reg_addr,
  input  logic [31:0]                       reg_wdata,
  output logic [31:0]                       reg_rdata,
  input  logic [NBLK-1:0]                   blk_lock,
  output logic                              rd_en,
  output logic [$clog2(NBLK+1)+WBITS-1:0]   rd_addr,
  output logic                              rd_margin_val,
  output logic                              rd_ecc_bypass,
  input  logic [SIG_W-1:0]                  rd_data
);

  localparam int BBITS = $clog2(NBLK+1);
  localparam int BSPAN = 1 << BBITS;

  logic             rst_s0, rst_i;
  scan_st_e         st_q, st_d;
  logic             en_q, en_d;
  logic             seq_q, men_q, mval_q;
  logic [NBLK-1:0]  mask_q, act_q, act_d;
  logic             cfg_we, mask_we, act_we;
  logic             vld_q, upd;
  logic             load, step, alt;
  logic             wr_ctrl, wr_mask;
  logic [BBITS-1:0] blk;
  logic [WBITS-1:0] word;
  logic             cur_act, last;
  logic [SIG_WORDS-1:0] seed_we;
  logic [SIG_W-1:0] sig;
  logic [BSPAN-1:0] lock_ext;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0 <= 1'b0;
      rst_i  <= 1'b0;
    end else begin
      rst_s0 <= 1'b1;
      rst_i  <= rst_s0;
    end
  end

  assign wr_ctrl = reg_wr && (reg_addr == RA_CTRL);
  assign wr_mask = reg_wr && (reg_addr == RA_MASK);

  for (genvar k = 0; k < SIG_WORDS; k++) begin : g_seed
    assign seed_we[k] = reg_wr && (st_q == ST_IDLE) && (reg_addr == RA_SIG0 + 3'(k));
  end

  // next state
  always_comb begin
    st_d    = st_q;
    en_d    = en_q;
    act_d   = act_q;
    cfg_we  = 1'b0;
    mask_we = 1'b0;
    act_we  = 1'b0;
    load    = 1'b0;
    step    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        mask_we = wr_mask;
        if (wr_ctrl) begin
          cfg_we = 1'b1;
          en_d   = reg_wdata[0];
          if (reg_wdata[0]) begin
            st_d   = ST_SCAN;
            load   = 1'b1;
            act_we = 1'b1;
            act_d  = mask_q & ~blk_lock;
          end
        end
      end
      ST_SCAN: begin
        step = 1'b1;
        if (last) st_d = ST_DRAIN;
      end
      ST_DRAIN: st_d = ST_DONE;
      ST_DONE:  st_d = ST_DONE;
      default:  st_d = ST_IDLE;
    endcase
    if ((st_q != ST_IDLE) && wr_ctrl && !reg_wdata[0]) begin
      st_d = ST_IDLE;
      en_d = 1'b0;
      step = 1'b0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st_q   <= ST_IDLE;
      en_q   <= 1'b0;
      seq_q  <= 1'b0;
      men_q  <= 1'b0;
      mval_q <= 1'b0;
      mask_q <= '0;
      act_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      en_q  <= en_d;
      vld_q <= rd_en;
      if (cfg_we) begin
        seq_q  <= reg_wdata[2];
        men_q  <= reg_wdata[3];
        mval_q <= reg_wdata[4];
      end
      if (mask_we) mask_q <= reg_wdata[NBLK-1:0];
      if (act_we)  act_q  <= act_d;
    end
  end

  assign alt = seq_q & ~men_q;

  sig_addr_gen #(.NBLK(NBLK), .WBITS(WBITS), .BBITS(BBITS)) u_agen (
    .clk(clk), .rst_n(rst_i), .load(load), .step(step), .act(act_q), .alt(alt),
    .blk_o(blk), .word_o(word), .cur_act_o(cur_act), .last_o(last)
  );

  assign upd = vld_q && ((st_q == ST_SCAN) || (st_q == ST_DRAIN));

  sig_misr #(.NWORD(SIG_WORDS), .TAPS(SIG_TAPS)) u_misr (
    .clk(clk), .rst_n(rst_i), .seed_we(seed_we), .seed_wdata(reg_wdata),
    .upd(upd), .beat(rd_data), .sig_o(sig)
  );

  assign rd_en         = (st_q == ST_SCAN) && cur_act;
  assign rd_addr       = {blk, word};
  assign rd_margin_val = mval_q;
  assign rd_ecc_bypass = rd_en && men_q;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == RA_CTRL)
      reg_rdata = {27'd0, mval_q, men_q, seq_q, (st_q == ST_DONE), en_q};
    else if (reg_addr == RA_MASK)
      reg_rdata = 32'(mask_q);
    for (int k = 0; k < SIG_WORDS; k++) begin
      if (reg_addr == RA_SIG0 + 3'(k)) reg_rdata = sig[k*32 +: 32];
    end
  end

  assign lock_ext = BSPAN'(blk_lock);

  // R7: shadow block index never addressed
  p_no_shadow_r7: assert property (@(posedge clk) disable iff (!rst_i)
    rd_en |-> (blk < BBITS'(NBLK)));

  // R6: locked blocks are not read (locks stable during a scan)
  p_unlocked_r6: assert property (@(posedge clk) disable iff (!rst_i)
    rd_en |-> !lock_ext[blk]);

  // R5: margin mode walks words strictly upward
  p_margin_seq_r5: assert property (@(posedge clk) disable iff (!rst_i)
    (rd_en && $past(rd_en) && men_q && (blk == $past(blk)))
      |-> (word == WBITS'($past(word) + 1'b1)));

  // R11: done only while enable is still set
  p_done_en_r11: assert property (@(posedge clk) disable iff (!rst_i)
    (st_q == ST_DONE) |-> en_q);

  // R9: signature frozen while done
  p_sig_frozen_r9: assert property (@(posedge clk) disable iff (!rst_i)
    (st_q == ST_DONE) |=> $stable(sig));

endmodule

// File: tb/sig_scan_ctrl_test.sv
`timescale 1ns/1ps
module sig_scan_ctrl_test;

  localparam int NBLK = 4;
  localparam int WB   = 3;
  localparam int AW   = 6;
  localparam logic [159:0] TAPS_TB = 160'hE0000000_00000000_00000000_00000000_00000001;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_wr;
  logic [2:0]    reg_addr;
  logic [31:0]   reg_wdata, reg_rdata;
  logic [3:0]    blk_lock;
  logic          rd_en, rd_margin_val, rd_ecc_bypass;
  logic [AW-1:0] rd_addr;
  logic [159:0]  rd_data;

  int checks = 0;
  int errors = 0;
  bit summary_done = 0;

  logic [AW-1:0] exp_addr [0:63];
  logic [AW-1:0] got_addr [0:63];
  int n_exp, n_got, shadow_hits, mon_bad;
  logic exp_byp, exp_mval;

  always #2 clk = ~clk;

  sig_scan_ctrl #(.NBLK(NBLK), .WBITS(WB)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .blk_lock(blk_lock),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_margin_val(rd_margin_val),
    .rd_ecc_bypass(rd_ecc_bypass), .rd_data(rd_data)
  );

  function automatic logic [159:0] beat_of(logic [AW-1:0] a);
    logic [159:0] r;
    for (int k = 0; k < 5; k++)
      r[k*32 +: 32] = (32'h9E3779B9 * (32'(a) + 1)) ^ (32'h01000193 * (k + 7)) ^ {26'd0, a};
    return r;
  endfunction

  function automatic logic [159:0] step_sig(logic [159:0] s, logic [159:0] d);
    return ({s[158:0], 1'b0} ^ d) ^ (s[159] ? TAPS_TB : 160'd0);
  endfunction

  // array model: one register of latency
  always @(posedge clk) rd_data <= beat_of(rd_addr);

  always @(negedge clk) begin
    if (rd_en) begin
      if (n_got < 64) got_addr[n_got] = rd_addr;
      n_got++;
      if (rd_addr[5:3] >= 3'(NBLK)) shadow_hits++;
      if (rd_ecc_bypass !== exp_byp || rd_margin_val !== exp_mval) mon_bad++;
    end
  end

  task automatic summary();
    if (!summary_done) begin
      summary_done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  task automatic chk(bit ok, string req, logic [159:0] act, logic [159:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_reg(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic read_reg(logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic read_sig(output logic [159:0] s);
    logic [31:0] w;
    for (int k = 0; k < 5; k++) begin
      read_reg(3'(2 + k), w);
      s[k*32 +: 32] = w;
    end
  endtask

  task automatic seed_sig(logic [159:0] s);
    for (int k = 0; k < 5; k++) write_reg(3'(2 + k), s[k*32 +: 32]);
  endtask

  task automatic build_expect(logic [3:0] mask, logic [3:0] lock, bit alt);
    n_exp = 0;
    for (int b = 0; b < NBLK; b++) begin
      if (mask[b] && !lock[b]) begin
        for (int w = 0; w < 8; w++) begin
          logic [2:0] wv;
          wv = 3'(w);
          exp_addr[n_exp] = {3'(b), alt ? {wv[0], wv[1], wv[2]} : wv};
          n_exp++;
        end
      end
    end
  endtask

  function automatic logic [159:0] model_sig(logic [159:0] seed, int n);
    logic [159:0] s = seed;
    for (int i = 0; i < n; i++) s = step_sig(s, beat_of(exp_addr[i]));
    return s;
  endfunction

  task automatic wait_done(output bit ok);
    logic [31:0] c;
    ok = 0;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      read_reg(3'd0, c);
      if (c[1]) begin ok = 1; break; end
    end
  endtask

  task automatic start_scan(logic [159:0] seed, logic [3:0] mask, logic [3:0] lock,
                            bit seq, bit men, bit mval);
    @(negedge clk);
    blk_lock = lock;
    seed_sig(seed);
    write_reg(3'd1, 32'(mask));
    build_expect(mask, lock, seq && !men);
    n_got = 0; shadow_hits = 0; mon_bad = 0;
    exp_byp = men; exp_mval = mval;
    write_reg(3'd0, {27'd0, mval, men, seq, 1'b0, 1'b1});
  endtask

  task automatic finish_scan(logic [159:0] seed, string req);
    bit ok;
    bit order_ok = 1;
    logic [159:0] s;
    logic [31:0] c;
    wait_done(ok);
    chk(ok, {"R2 done ", req}, 160'(ok), 160'd1);
    chk(n_got == n_exp, {"R2 read count ", req}, 160'(n_got), 160'(n_exp));
    for (int i = 0; i < n_exp && i < n_got; i++)
      if (got_addr[i] !== exp_addr[i]) order_ok = 0;
    chk(order_ok, {"address order ", req}, 160'(order_ok), 160'd1);
    chk(shadow_hits == 0, {"R7 shadow ", req}, 160'(shadow_hits), 160'd0);
    chk(mon_bad == 0, {"R5 margin/bypass pins ", req}, 160'(mon_bad), 160'd0);
    read_sig(s);
    chk(s === model_sig(seed, n_exp), {"R8 signature ", req}, s, model_sig(seed, n_exp));
    write_reg(3'd0, 32'd0);
    read_reg(3'd0, c);
    chk(c[1:0] == 2'b00, "R11 idle after clear", 160'(c[1:0]), 160'd0);
    read_sig(s);
    chk(s === model_sig(seed, n_exp), "R11 signature kept", s, model_sig(seed, n_exp));
  endtask

  task automatic t_reset();
    logic [31:0] c, m;
    logic [159:0] s;
    read_reg(3'd0, c);
    read_reg(3'd1, m);
    read_sig(s);
    chk(c == 32'd0 && m == 32'd0, "R1 ctrl/mask reset", 160'({c, m}), 160'd0);
    chk(s == 160'd0, "R1 signature reset", s, 160'd0);
    chk(rd_en == 1'b0, "R1 no read", 160'(rd_en), 160'd0);
  endtask

  task automatic t_sequential();
    logic [159:0] seed = {32'h1234_5678, 32'h0, 32'hFFFF_0000, 32'hDEAD_BEEF, 32'h8000_0001};
    start_scan(seed, 4'hF, 4'h0, 0, 0, 0);
    finish_scan(seed, "R3 sequential");
  endtask

  task automatic t_bitrev();
    logic [159:0] seed = {5{32'hA5A5_5A5A}};
    start_scan(seed, 4'b0110, 4'h0, 1, 0, 1);
    finish_scan(seed, "R4 bit-reversed");
  endtask

  task automatic t_margin();
    logic [159:0] seed = {32'h0, 32'h1, 32'h2, 32'h3, 32'h4};
    start_scan(seed, 4'hF, 4'h0, 1, 1, 1);
    finish_scan(seed, "R5 margin ones");
    start_scan(seed, 4'b1001, 4'h0, 1, 1, 0);
    finish_scan(seed, "R5 margin zeros");
  endtask

  task automatic t_mask_lock();
    logic [159:0] seed = {32'hCAFE_F00D, 32'h0BAD_0BAD, 32'h7777_1111, 32'h0, 32'h55AA_55AA};
    start_scan(seed, 4'b1101, 4'b0100, 0, 0, 0);
    finish_scan(seed, "R6 mask and lock");
    start_scan(seed, 4'b0011, 4'b0011, 0, 0, 0);
    finish_scan(seed, "R6 all locked");
    blk_lock = 4'h0;
  endtask

  task automatic t_seed_ignored();
    logic [159:0] seed = {32'h1111_2222, 32'h3333_4444, 32'h5555_6666, 32'h7777_8888, 32'h9999_AAAA};
    logic [159:0] s;
    bit ok;
    start_scan(seed, 4'hF, 4'h0, 0, 0, 0);
    write_reg(3'd2, 32'hFFFF_FFFF);
    write_reg(3'd6, 32'h0000_0000);
    wait_done(ok);
    write_reg(3'd4, 32'h1357_9BDF);
    read_sig(s);
    chk(s === model_sig(seed, n_exp), "R9 seed writes ignored outside idle", s, model_sig(seed, n_exp));
    write_reg(3'd0, 32'd0);
    write_reg(3'd4, 32'h1357_9BDF);
    read_reg(3'd4, s[31:0]);
    chk(s[31:0] == 32'h1357_9BDF, "R9 seed write accepted when idle", 160'(s[31:0]), 160'h1357_9BDF);
  endtask

  task automatic t_abort();
    logic [159:0] seed = {32'h0F0F_0F0F, 32'hF0F0_F0F0, 32'h1, 32'h2, 32'h3};
    logic [159:0] s1, s2;
    logic [31:0] c;
    int hit = -1;
    start_scan(seed, 4'hF, 4'h0, 1, 0, 0);
    repeat (10) @(negedge clk);
    write_reg(3'd0, 32'd0);
    read_reg(3'd0, c);
    chk(c[1:0] == 2'b00, "R10 done low after abort", 160'(c[1:0]), 160'd0);
    read_sig(s1);
    repeat (8) @(negedge clk);
    read_sig(s2);
    chk(s1 === s2, "R10 signature frozen after abort", s2, s1);
    for (int n = 0; n <= n_exp; n++)
      if (hit < 0 && model_sig(seed, n) === s1) hit = n;
    chk(hit > 0 && hit < n_exp, "R10 partial prefix signature", 160'(hit), 160'(n_exp / 2));
    chk(rd_en == 1'b0, "R10 no reads after abort", 160'(rd_en), 160'd0);
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 3'd0; reg_wdata = 32'd0; blk_lock = 4'h0;
    n_got = 0; shadow_hits = 0; mon_bad = 0; exp_byp = 0; exp_mval = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_sequential();
    t_bitrev();
    t_margin();
    t_mask_lock();
    t_seed_ignored();
    t_abort();
    t_sequential();
    summary();
  end

endmodule